// File: doc/BRIEF.md
# Set-Associative Cache Tag Store

This block holds the tag side of a set-associative cache. Each request carries a byte address. The block cuts the address into a line offset, a set index and a tag, and it compares the tag against every way of the selected set at once. A lookup reports hit or miss, the way that matched and an access latency in cycles. That latency grows when the matched line is still waiting for its fill to complete. An install picks a victim way inside a run-time limit on how many ways may be allocated, writes the new tag and reports any valid line it displaced, giving the displaced line's address rebuilt from its tag and set. An invalidate removes a line by address. A limit write changes the allocation limit. Four running counters track tag probes, data-array reads, replacements of valid lines, and lines currently in use.

Requests are handled one at a time by a three-state controller. ST_IDLE holds `req_ready` high and captures a request (transition IDLE->EXEC on `req_valid`). ST_EXEC evaluates the captured request against the arrays and commits every update (transition EXEC->RESP, unconditional). ST_RESP presents the registered response with `resp_valid` high for one cycle (transition RESP->IDLE, unconditional). Each set also keeps a recency ordering of its ways, with position 0 the most recently used. Victim choice and promotion both work on this ordering.

Top module: `tsa_top`

## Requirements
- R1: After reset `req_ready` is 1, all four counters read 0, `cur_limit` equals WAYS, and every lookup misses. Every set's recency order starts as way index order, with position p holding way p.
- R2: Request `req_op` encodings are 0 = lookup, 1 = install, 2 = invalidate and 3 = limit write. The set index is address bits [OFF_W +: SET_W], and the tag is the bits above them. A lookup hits only when both set and tag match a valid entry. A different offset inside the same line still hits.
- R3: A miss, and any response that is not a hit, reports `resp_lat` = LOOKUP_LAT. A hit reports ACCESS_LAT when the line's remaining wait count is at most ACCESS_LAT.
- R4: On a hit whose remaining wait count exceeds ACCESS_LAT, `resp_lat` equals that count plus ACCESS_LAT. The wait count is loaded from `req_wait` when the install commits and then falls by one every cycle until it reaches 0.
- R5: An install walks recency positions 0 up to `cur_limit`-1 and takes the first way whose entry is invalid.
- R6: When every way in that window is valid, the install takes the way at recency position `cur_limit`-1.
- R7: A lookup hit moves the hit way to recency position 0 and shifts the ways that were more recent down by one position. An install does the same with the installed way. Misses, invalidations and limit writes leave the order unchanged.
- R8: A limit write with value 0 or greater than WAYS sets `resp_err` and leaves `cur_limit` unchanged. Any value from 1 to WAYS is taken.
- R9: A lookup adds WAYS to the tag-access count. With SEQ_MODE=1 it adds 1 to the data-access count on a hit and 0 on a miss; with SEQ_MODE=0 it adds WAYS on every lookup. An install adds 1 to each count. An invalidate adds WAYS to the tag-access count only.
- R10: An install over a valid entry sets `resp_evict`, returns the old line address (old tag and set, offset zero) on `resp_evict_addr`, returns that line's hit count on `resp_refs`, and increments the replacement count. The new line's hit count starts at 0.
- R11: Invalidating a present line reports a hit with its way, clears the entry, decrements the in-use count and returns the entry to the untouched state. Invalidating an absent line changes nothing.
- R12: An install into an untouched entry increments the in-use count. An install over a valid entry leaves the in-use count unchanged.
- R13: An accepted request drops `req_ready` and raises `resp_valid` for exactly one cycle two cycles after acceptance. `req_ready` returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_op | input | 2 | 0 lookup, 1 install, 2 invalidate, 3 limit write |
| req_addr | input | ADDR_W | Byte address |
| req_wait | input | READY_W | Cycles until an installed line is ready |
| req_limit | input | LIM_W | New allocation limit for a limit write |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Tag matched a valid entry |
| resp_err | output | 1 | Limit write rejected |
| resp_evict | output | 1 | Install displaced a valid line |
| resp_way | output | WAY_W | Hit way, or installed way |
| resp_lat | output | LAT_W | Access latency in cycles |
| resp_evict_addr | output | ADDR_W | Rebuilt address of the displaced line |
| resp_refs | output | REF_W | Hit count of hit line or displaced line |
| cur_limit | output | LIM_W | Current allocation limit |
| cnt_tag_acc | output | CNT_W | Tag probe count |
| cnt_data_acc | output | CNT_W | Data read count |
| cnt_repl | output | CNT_W | Replacements of valid lines |
| cnt_in_use | output | CNT_W | Entries in use |

## Verification
Recency order, valid bits and touched bits are hidden, so any error in them shows up only on a later install: the wrong way appears on `resp_way`, or an eviction appears or vanishes on `resp_evict`. The tests therefore fill a set completely, promote lines with hits and shrink the limit, so that each victim way depends on the exact ordering. A wrong wait counter shows on the first hit after an install, because `resp_lat` moves off its expected value by one cycle or more. The install-then-lookup pair is issued back to back so the remaining count is known exactly. Counter errors surface on the count ports at the end of the ST_EXEC cycle, which the bench reads in the ST_RESP cycle.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP  = 2'd0,
        OP_INSTALL = 2'd1,
        OP_INVAL   = 2'd2,
        OP_SETLIM  = 2'd3
    } tsa_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } tsa_state_e;

endpackage

// File: rtl/tsa_addr_split.sv
module tsa_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int SET_W  = 2,
    localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
    input  logic [ADDR_W-OFF_W-1:0] line_addr,
    output logic [SET_W-1:0]        set_idx,
    output logic [TAG_W-1:0]        tag,
    input  logic [TAG_W-1:0]        rg_tag,
    input  logic [SET_W-1:0]        rg_set,
    output logic [ADDR_W-1:0]       rg_addr
);

    // set field sits directly above the line offset, tag above the set field
    assign set_idx = line_addr[SET_W-1:0];
    assign tag     = line_addr[ADDR_W-OFF_W-1:SET_W];

    // rebuild a line address with a zero offset
    assign rg_addr = {rg_tag, rg_set, {OFF_W{1'b0}}};

endmodule

// File: rtl/tsa_victim_sel.sv
module tsa_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int LIM_W = $clog2(WAYS + 1)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] order,
    input  logic [WAYS-1:0]            valid,
    input  logic [LIM_W-1:0]           limit,
    output logic [WAY_W-1:0]           victim_way,
    output logic                       victim_valid
);

    logic             found;
    logic [WAY_W-1:0] pos;

    always_comb begin
        found = 1'b0;
        pos   = WAY_W'(limit - LIM_W'(1));
        for (int p = 0; p < WAYS; p++) begin
            if (!found && (LIM_W'(p) < limit) && !valid[order[p]]) begin
                found = 1'b1;
                pos   = WAY_W'(p);
            end
        end
        victim_way   = order[pos];
        victim_valid = valid[order[pos]];
    end

endmodule

// File: rtl/tsa_lru_update.sv
module tsa_lru_update #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] order_in,
    input  logic [WAY_W-1:0]           way,
    output logic [WAYS-1:0][WAY_W-1:0] order_out
);

    logic passed;

    always_comb begin
        passed       = 1'b0;
        order_out[0] = way;
        for (int p = 1; p < WAYS; p++) begin
            if (order_in[p-1] == way) passed = 1'b1;
            order_out[p] = passed ? order_in[p] : order_in[p-1];
        end
    end

endmodule

// File: rtl/tsa_top.sv
module tsa_top
    import tsa_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int READY_W    = 8,
    parameter int REF_W      = 8,
    parameter int CNT_W      = 16,
    parameter int ACCESS_LAT = 2,
    parameter int LOOKUP_LAT = 1,
    parameter bit SEQ_MODE   = 1'b1,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - SET_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int LIM_W = $clog2(WAYS + 1),
    localparam int LAT_W = READY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [READY_W-1:0] req_wait,
    input  logic [LIM_W-1:0]  req_limit,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_err,
    output logic              resp_evict,
    output logic [WAY_W-1:0]  resp_way,
    output logic [LAT_W-1:0]  resp_lat,
    output logic [ADDR_W-1:0] resp_evict_addr,
    output logic [REF_W-1:0]  resp_refs,
    output logic [LIM_W-1:0]  cur_limit,
    output logic [CNT_W-1:0]  cnt_tag_acc,
    output logic [CNT_W-1:0]  cnt_data_acc,
    output logic [CNT_W-1:0]  cnt_repl,
    output logic [CNT_W-1:0]  cnt_in_use
);

    // ---------------- controller ----------------
    tsa_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign resp_valid = (state_q == ST_RESP);

    logic accept, exec;
    assign accept = req_valid && req_ready;
    assign exec   = (state_q == ST_EXEC);

    // ---------------- captured request ----------------
    tsa_op_e                 op_q;
    logic [ADDR_W-OFF_W-1:0] line_q;
    logic [READY_W-1:0]      wait_q;
    logic [LIM_W-1:0]        lim_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_LOOKUP;
            line_q <= '0;
            wait_q <= '0;
            lim_q  <= '0;
        end else if (accept) begin
            op_q   <= tsa_op_e'(req_op);
            line_q <= req_addr[ADDR_W-1:OFF_W];
            wait_q <= req_wait;
            lim_q  <= req_limit;
        end
    end

    // ---------------- storage ----------------
    logic [TAG_W-1:0]          tag_q      [SETS][WAYS];
    logic [READY_W-1:0]        wait_cnt_q [SETS][WAYS];
    logic [REF_W-1:0]          refs_q     [SETS][WAYS];
    logic [WAYS-1:0]           valid_q    [SETS];
    logic [WAYS-1:0]           touched_q  [SETS];
    logic [WAYS-1:0][WAY_W-1:0] order_q   [SETS];
    logic [LIM_W-1:0]          limit_q;

    // ---------------- address handling ----------------
    logic [SET_W-1:0]  set_i;
    logic [TAG_W-1:0]  tag_i;
    logic [ADDR_W-1:0] regen_addr;
    logic [WAY_W-1:0]  victim_way;
    logic              victim_valid;

    tsa_addr_split #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .SET_W  (SET_W)
    ) u_split (
        .line_addr (line_q),
        .set_idx   (set_i),
        .tag       (tag_i),
        .rg_tag    (tag_q[set_i][victim_way]),
        .rg_set    (set_i),
        .rg_addr   (regen_addr)
    );

    // ---------------- parallel tag compare ----------------
    logic [WAYS-1:0]  hit_vec;
    logic             hit_any;
    logic [WAY_W-1:0] hit_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
        end
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit_any = |hit_vec;

    // ---------------- latency ----------------
    logic [READY_W-1:0] rem_wait;
    logic [LAT_W-1:0]   lat_hit;

    assign rem_wait = wait_cnt_q[set_i][hit_way];
    assign lat_hit  = (LAT_W'(rem_wait) > LAT_W'(ACCESS_LAT))
                    ? LAT_W'(rem_wait) + LAT_W'(ACCESS_LAT)
                    : LAT_W'(ACCESS_LAT);

    // ---------------- victim and recency ----------------
    logic [WAYS-1:0][WAY_W-1:0] order_next;
    logic [WAY_W-1:0]           mru_way;

    tsa_victim_sel #(.WAYS(WAYS)) u_victim (
        .order        (order_q[set_i]),
        .valid        (valid_q[set_i]),
        .limit        (limit_q),
        .victim_way   (victim_way),
        .victim_valid (victim_valid)
    );

    assign mru_way = (op_q == OP_INSTALL) ? victim_way : hit_way;

    tsa_lru_update #(.WAYS(WAYS)) u_lru (
        .order_in  (order_q[set_i]),
        .way       (mru_way),
        .order_out (order_next)
    );

    logic [REF_W-1:0] refs_hit, refs_hit_inc;
    assign refs_hit     = refs_q[set_i][hit_way];
    assign refs_hit_inc = (&refs_hit) ? refs_hit : refs_hit + REF_W'(1);

    logic victim_fresh;
    assign victim_fresh = !touched_q[set_i][victim_way];

    // ---------------- array updates ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s]   <= '0;
                touched_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]      <= '0;
                    wait_cnt_q[s][w] <= '0;
                    refs_q[s][w]     <= '0;
                    order_q[s][w]    <= WAY_W'(w);
                end
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (wait_cnt_q[s][w] != '0)
                        wait_cnt_q[s][w] <= wait_cnt_q[s][w] - READY_W'(1);
                end
            end
            if (exec) begin
                unique case (op_q)
                    OP_LOOKUP: begin
                        if (hit_any) begin
                            order_q[set_i]         <= order_next;
                            refs_q[set_i][hit_way] <= refs_hit_inc;
                        end
                    end
                    OP_INSTALL: begin
                        tag_q[set_i][victim_way]      <= tag_i;
                        valid_q[set_i][victim_way]    <= 1'b1;
                        touched_q[set_i][victim_way]  <= 1'b1;
                        wait_cnt_q[set_i][victim_way] <= wait_q;
                        refs_q[set_i][victim_way]     <= '0;
                        order_q[set_i]                <= order_next;
                    end
                    OP_INVAL: begin
                        if (hit_any) begin
                            valid_q[set_i][hit_way]   <= 1'b0;
                            touched_q[set_i][hit_way] <= 1'b0;
                        end
                    end
                    OP_SETLIM: ;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- response, limit and counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_hit        <= 1'b0;
            resp_err        <= 1'b0;
            resp_evict      <= 1'b0;
            resp_way        <= '0;
            resp_lat        <= LAT_W'(LOOKUP_LAT);
            resp_evict_addr <= '0;
            resp_refs       <= '0;
            limit_q         <= LIM_W'(WAYS);
            cnt_tag_acc     <= '0;
            cnt_data_acc    <= '0;
            cnt_repl        <= '0;
            cnt_in_use      <= '0;
        end else if (exec) begin
            resp_hit        <= 1'b0;
            resp_err        <= 1'b0;
            resp_evict      <= 1'b0;
            resp_way        <= '0;
            resp_lat        <= LAT_W'(LOOKUP_LAT);
            resp_evict_addr <= '0;
            resp_refs       <= '0;
            unique case (op_q)
                OP_LOOKUP: begin
                    resp_hit    <= hit_any;
                    resp_way    <= hit_way;
                    cnt_tag_acc <= cnt_tag_acc + CNT_W'(WAYS);
                    if (hit_any) begin
                        resp_lat  <= lat_hit;
                        resp_refs <= refs_hit_inc;
                    end
                    if (!SEQ_MODE)
                        cnt_data_acc <= cnt_data_acc + CNT_W'(WAYS);
                    else if (hit_any)
                        cnt_data_acc <= cnt_data_acc + CNT_W'(1);
                end
                OP_INSTALL: begin
                    resp_way     <= victim_way;
                    resp_evict   <= victim_valid;
                    cnt_tag_acc  <= cnt_tag_acc + CNT_W'(1);
                    cnt_data_acc <= cnt_data_acc + CNT_W'(1);
                    if (victim_valid) begin
                        resp_evict_addr <= regen_addr;
                        resp_refs       <= refs_q[set_i][victim_way];
                        cnt_repl        <= cnt_repl + CNT_W'(1);
                    end
                    if (victim_fresh)
                        cnt_in_use <= cnt_in_use + CNT_W'(1);
                end
                OP_INVAL: begin
                    resp_hit    <= hit_any;
                    resp_way    <= hit_way;
                    cnt_tag_acc <= cnt_tag_acc + CNT_W'(WAYS);
                    if (hit_any) begin
                        resp_lat   <= lat_hit;
                        cnt_in_use <= cnt_in_use - CNT_W'(1);
                    end
                end
                OP_SETLIM: begin
                    if (lim_q == '0 || lim_q > LIM_W'(WAYS))
                        resp_err <= 1'b1;
                    else
                        limit_q <= lim_q;
                end
                default: ;
            endcase
        end
    end

    assign cur_limit = limit_q;

endmodule

// File: rtl/tsa_checker.sv
module tsa_checker #(
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int CNT_W      = 16,
    parameter int LAT_W      = 9,
    parameter int ACCESS_LAT = 2,
    parameter int LOOKUP_LAT = 1,
    localparam int LIM_W = $clog2(WAYS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             resp_err,
    input logic [LAT_W-1:0] resp_lat,
    input logic [LIM_W-1:0] cur_limit,
    input logic [CNT_W-1:0] cnt_repl,
    input logic [CNT_W-1:0] cnt_in_use,
    input logic [CNT_W-1:0] cnt_tag_acc
);

    p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !resp_valid));

    p_resp_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    p_resp_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    p_miss_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_lat == LAT_W'(LOOKUP_LAT)));

    p_hit_lat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (resp_lat >= LAT_W'(ACCESS_LAT)));

    p_limit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_limit >= LIM_W'(1)) && (cur_limit <= LIM_W'(WAYS)));

    p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> $stable(cur_limit));

    p_repl_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_repl == $past(cnt_repl)) || (cnt_repl == $past(cnt_repl) + CNT_W'(1)));

    p_in_use_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_in_use <= CNT_W'(SETS * WAYS));

    p_tag_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tag_acc >= $past(cnt_tag_acc));

endmodule

bind tsa_top tsa_checker #(
    .WAYS       (WAYS),
    .SETS       (SETS),
    .CNT_W      (CNT_W),
    .LAT_W      (LAT_W),
    .ACCESS_LAT (ACCESS_LAT),
    .LOOKUP_LAT (LOOKUP_LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_err    (resp_err),
    .resp_lat    (resp_lat),
    .cur_limit   (cur_limit),
    .cnt_repl    (cnt_repl),
    .cnt_in_use  (cnt_in_use),
    .cnt_tag_acc (cnt_tag_acc)
);

// File: tb/tsa_top_tb.sv
`timescale 1ns/1ps
module tsa_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_wait = '0;
    logic [2:0]  req_limit = '0;
    logic        resp_valid, resp_hit, resp_err, resp_evict;
    logic [1:0]  resp_way;
    logic [8:0]  resp_lat;
    logic [31:0] resp_evict_addr;
    logic [7:0]  resp_refs;
    logic [2:0]  cur_limit;
    logic [15:0] cnt_tag_acc, cnt_data_acc, cnt_repl, cnt_in_use;

    always #4 clk = ~clk;

    tsa_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wait(req_wait), .req_limit(req_limit),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_err(resp_err),
        .resp_evict(resp_evict), .resp_way(resp_way), .resp_lat(resp_lat),
        .resp_evict_addr(resp_evict_addr), .resp_refs(resp_refs), .cur_limit(cur_limit),
        .cnt_tag_acc(cnt_tag_acc), .cnt_data_acc(cnt_data_acc),
        .cnt_repl(cnt_repl), .cnt_in_use(cnt_in_use)
    );

    localparam logic [1:0] LOOKUP = 2'd0, INSTALL = 2'd1, INVAL = 2'd2, SETLIM = 2'd3;

    int n_chk = 0;
    int n_err = 0;
    int e_tag = 0, e_data = 0, e_repl = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // issue one request from an idle negedge; returns at the next idle negedge
    task automatic do_op(input logic [1:0] op, input logic [31:0] addr,
                         input logic [7:0] wt, input logic [2:0] lim);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wait = wt; req_limit = lim;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13", "busy after accept", {req_ready, resp_valid}, 2'b00);
        @(negedge clk);
        chk("R13", "resp_valid two cycles later", resp_valid, 1);
        if (op == LOOKUP) begin
            e_tag += 4;
            if (resp_hit) e_data += 1;
        end else if (op == INSTALL) begin
            e_tag += 1; e_data += 1;
            if (resp_evict) e_repl += 1;
        end else if (op == INVAL) begin
            e_tag += 4;
        end
        @(negedge clk);
        chk("R13", "idle after response", {req_ready, resp_valid}, 2'b10);
    endtask

    task automatic t_reset();
        chk("R1", "ready", req_ready, 1);
        chk("R1", "counters", {cnt_tag_acc, cnt_data_acc, cnt_repl, cnt_in_use}, 0);
        chk("R1", "limit", cur_limit, 4);
        do_op(LOOKUP, 32'h0, 8'd0, 3'd0);
        chk("R1", "empty lookup miss", resp_hit, 0);
        chk("R3", "miss latency", resp_lat, 1);
    endtask

    task automatic t_fill();
        do_op(INSTALL, 32'h40, 8'd0, 3'd0);
        chk("R5", "A way", resp_way, 0);
        chk("R5", "A no evict", resp_evict, 0);
        do_op(INSTALL, 32'h80, 8'd0, 3'd0);
        chk("R5", "B way", resp_way, 1);
        do_op(INSTALL, 32'hC0, 8'd0, 3'd0);
        chk("R5", "C way", resp_way, 2);
        do_op(INSTALL, 32'h100, 8'd0, 3'd0);
        chk("R5", "D way", resp_way, 3);
        chk("R12", "in use after fill", cnt_in_use, 4);
    endtask

    task automatic t_hit();
        do_op(LOOKUP, 32'h40, 8'd0, 3'd0);
        chk("R2", "A hit", resp_hit, 1);
        chk("R2", "A way", resp_way, 0);
        chk("R3", "ready hit latency", resp_lat, 2);
        chk("R10", "refs after one hit", resp_refs, 1);
        do_op(LOOKUP, 32'h4C, 8'd0, 3'd0);
        chk("R2", "other offset hit", {resp_hit, resp_way}, {1'b1, 2'd0});
        do_op(LOOKUP, 32'h50, 8'd0, 3'd0);
        chk("R2", "same tag other set miss", resp_hit, 0);
    endtask

    task automatic t_evict();
        // order now A,D,C,B: LRU position holds B (way 1)
        do_op(INSTALL, 32'h140, 8'd0, 3'd0);
        chk("R6", "full set victim", resp_way, 1);
        chk("R10", "evict flag", resp_evict, 1);
        chk("R10", "evict addr", resp_evict_addr, 32'h80);
        chk("R10", "evict refs", resp_refs, 0);
        chk("R10", "repl count", cnt_repl, 1);
        chk("R12", "in use unchanged", cnt_in_use, 4);
        do_op(LOOKUP, 32'h80, 8'd0, 3'd0);
        chk("R7", "B gone", resp_hit, 0);
    endtask

    task automatic t_limit();
        do_op(SETLIM, 32'h0, 8'd0, 3'd0);
        chk("R8", "zero rejected", {resp_err, cur_limit}, {1'b1, 3'd4});
        do_op(SETLIM, 32'h0, 8'd0, 3'd5);
        chk("R8", "too large rejected", {resp_err, cur_limit}, {1'b1, 3'd4});
        do_op(SETLIM, 32'h0, 8'd0, 3'd2);
        chk("R8", "two taken", {resp_err, cur_limit}, {1'b0, 3'd2});
        // order E,A,D,C: limit 2 picks position 1 = A (way 0)
        do_op(INSTALL, 32'h180, 8'd0, 3'd0);
        chk("R6", "limited victim way", resp_way, 0);
        chk("R10", "limited evict addr", resp_evict_addr, 32'h40);
        chk("R10", "A hit count", resp_refs, 2);
        do_op(SETLIM, 32'h0, 8'd0, 3'd4);
        chk("R8", "four taken", cur_limit, 4);
    endtask

    task automatic t_inval();
        do_op(INVAL, 32'hC0, 8'd0, 3'd0);
        chk("R11", "inval hit way", {resp_hit, resp_way}, {1'b1, 2'd2});
        chk("R11", "in use down", cnt_in_use, 3);
        do_op(INVAL, 32'hC0, 8'd0, 3'd0);
        chk("R11", "absent inval", {resp_hit, cnt_in_use}, {1'b0, 16'd3});
        do_op(LOOKUP, 32'hC0, 8'd0, 3'd0);
        chk("R11", "C miss", resp_hit, 0);
        // order F,E,D,C: C slot (way 2) at position 3 is the only invalid one
        do_op(INSTALL, 32'h1C0, 8'd0, 3'd0);
        chk("R5", "invalid slot reused", {resp_way, resp_evict}, {2'd2, 1'b0});
        chk("R12", "untouched again", cnt_in_use, 4);
    endtask

    task automatic t_ready();
        do_op(INSTALL, 32'h210, 8'd5, 3'd0);
        chk("R5", "set1 first way", resp_way, 0);
        do_op(LOOKUP, 32'h210, 8'd0, 3'd0);
        chk("R4", "stretched latency", resp_lat, 5);
        do_op(INSTALL, 32'h250, 8'd4, 3'd0);
        chk("R5", "set1 second way", resp_way, 1);
        do_op(LOOKUP, 32'h250, 8'd0, 3'd0);
        chk("R4", "boundary not stretched", resp_lat, 2);
        chk("R12", "in use six", cnt_in_use, 6);
    endtask

    task automatic t_counters();
        chk("R9", "tag accesses", cnt_tag_acc, e_tag);
        chk("R9", "data accesses", cnt_data_acc, e_data);
        chk("R10", "replacements", cnt_repl, e_repl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_hit();
        t_evict();
        t_limit();
        t_inval();
        t_ready();
        t_counters();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R13 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule